// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block decides when a small 8-bit processor core leaves its instruction stream for a service routine, and runs the fixed steps of that change. It watches four hardware request sources and one software request. Each hardware source has a pending flag and an enable bit, and all four are gated by a global enable bit G in the status register. The software request is raised when the core executes its software-interrupt instruction, and it is accepted whatever the state of G. The block accepts a request only in the cycle in which the core reports that its current instruction has finished. If several requests qualify at once, it picks one by fixed rank. It then holds the core for a fixed number of cycles. During that time it writes the 12-bit return address to a byte-wide stack and finally hands the core the winner's vector address.

The block also runs the two return instructions. Both pop the return address back off the stack, in the reverse of the push order. The interrupt-return form sets G again; the plain return leaves G as it is. The block owns the status register. An ordinary data write can change only G. A dedicated write, used by the special status instructions, loads every bit. The pending flags belong to the peripherals: the block never clears them, so the service routine must.

Stack storage and instruction decode sit outside. The stack is a plain synchronous port with no handshake, because the entry timing is fixed and cannot wait for a stall. The core is likewise held through a plain `busy` level rather than a valid/ready pair.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only at a clock edge where `instr_done` is 1 while the block is idle. While `instr_done` is 0, `busy` stays 0 whatever the request inputs are.
- R2: Hardware source k qualifies when `irq_pend[k]`, `irq_en[k]` and G are all 1. The software request `swi_req` qualifies whether G is 0 or 1. If nothing qualifies, `busy` stays 0.
- R3: After acceptance, `busy` is 1 for exactly ENTRY_CYC (5) cycles. `pc_load` is 1 only in the last of those cycles, with `pc_load_val` equal to the winner's vector.
- R4: Entry cycle 1 writes the low PC byte to address `sp_q`. Entry cycle 2 writes the upper four PC bits, zero-extended to a byte, to `sp_q`-1. The stack pointer decrements once per push. `stk_we` and `stk_re` are never both 1.
- R5: G (status bit 0) reads 0 from the first entry cycle onward.
- R6: The rank from highest to lowest is software, source 0, source 1, source 2, source 3. `vec_tbl[12*i +: 12]` is the vector for index i, where i=0 is software and i=k+1 is hardware source k. Bit k of `irq_pend` and `irq_en` is source k.
- R7: On `reti_req` the block is busy for 2 cycles. The first cycle reads the high byte from `sp_q`+1. The second reads the low byte from `sp_q`+1, pulses `pc_load` with the rebuilt address, and sets G to 1. The stack pointer increments once per pop.
- R8: `ret_req` performs the same two pops and the same `pc_load`, but leaves G unchanged.
- R9: With `sr_data_we`, only status bit 0 (G) takes the value of `sr_wdata`. With `sr_ded_we`, all 8 bits load. No other write changes status bits 1 to 7.
- R10: `instr_done` and request inputs have no effect while `busy` is 1. A hardware request still pending after entry is not taken while G is 0, but a software request then is.
- R11: After reset, `busy` is 0, `sr_q` is 0 and `sp_q` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | Current instruction finishes this cycle |
| swi_req | input | 1 | Software-interrupt instruction executed |
| irq_pend | input | 4 | Hardware pending flags, bit k = source k |
| irq_en | input | 4 | Hardware enable bits |
| cur_pc | input | 12 | Return address of the next instruction |
| vec_tbl | input | 60 | Five 12-bit vectors, index 0 = software |
| ret_req | input | 1 | Plain return instruction |
| reti_req | input | 1 | Interrupt-return instruction |
| sr_data_we | input | 1 | Ordinary data write to the status register |
| sr_ded_we | input | 1 | Dedicated status-register load |
| sr_wdata | input | 8 | Status write data |
| sr_q | output | 8 | Status register, bit 0 = G |
| busy | output | 1 | Core held by the sequencer |
| pc_load | output | 1 | Load `pc_load_val` into the PC |
| pc_load_val | output | 12 | New PC value |
| stk_we | output | 1 | Stack byte write |
| stk_re | output | 1 | Stack byte read |
| stk_addr | output | 8 | Stack address |
| stk_wdata | output | 8 | Stack write byte |
| stk_rdata | input | 8 | Stack read byte, same cycle as `stk_addr` |
| sp_q | output | 8 | Stack pointer, next free byte |

## Verification
The bench builds the block with its defaults: a 12-bit PC, 8-bit stack data and pointer, a 5-cycle entry, and the status flag at bit 0. With these values a nested entry moves the pointer from 0xFF down to 0xFB and back. That exercises the reverse pop order across two saved addresses. The five-cycle window is short enough to check every entry cycle one by one, including the cycle in which the vector appears.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ENTER = 2'd1,
    SEQ_LEAVE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NREQ = 5,
  localparam int IW = $clog2(NREQ)
) (
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] grant,
  output logic [IW-1:0]   win_idx,
  output logic            any
);
  logic [NREQ-1:0] seen;

  // Lowest index wins: the chain marks every position above a request.
  assign seen[0] = 1'b0;
  genvar i;
  generate
    for (i = 1; i < NREQ; i++) begin : g_chain
      assign seen[i] = seen[i-1] | req[i-1];
    end
    for (i = 0; i < NREQ; i++) begin : g_grant
      assign grant[i] = req[i] & ~seen[i];
    end
  endgenerate

  always_comb begin
    win_idx = '0;
    for (int k = 0; k < NREQ; k++) begin
      if (grant[k]) win_idx = IW'(k);
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int SR_W  = 8,
  parameter int G_BIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            data_we,
  input  logic            ded_we,
  input  logic [SR_W-1:0] wdata,
  input  logic            g_clr,
  input  logic            g_set,
  output logic [SR_W-1:0] sr_q
);
  logic [SR_W-1:0] sr_nxt;

  always_comb begin
    sr_nxt = sr_q;
    if (ded_we)       sr_nxt = wdata;
    else if (data_we) sr_nxt[G_BIT] = wdata[G_BIT];
    if (g_set)        sr_nxt[G_BIT] = 1'b1;
    if (g_clr)        sr_nxt[G_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_nxt;
  end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm import irq_pkg::*; #(
  parameter int          PC_W      = 12,
  parameter int          DW        = 8,
  parameter int          SP_W      = 8,
  parameter logic [7:0]  SP_INIT   = 8'hFF,
  parameter int          NREQ      = 5,
  parameter int          ENTRY_CYC = 5,
  localparam int IW   = $clog2(NREQ),
  localparam int CW   = $clog2(ENTRY_CYC + 1),
  localparam int HI_W = PC_W - DW,
  localparam int PADW = DW - HI_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_done,
  input  logic               any,
  input  logic [IW-1:0]      win_idx,
  input  logic [NREQ*PC_W-1:0] vec_tbl,
  input  logic [PC_W-1:0]    cur_pc,
  input  logic               ret_req,
  input  logic               reti_req,
  input  logic [DW-1:0]      stk_rdata,
  output logic               busy,
  output logic               g_clr,
  output logic               g_set,
  output logic               pc_load,
  output logic [PC_W-1:0]    pc_load_val,
  output logic               stk_we,
  output logic               stk_re,
  output logic [SP_W-1:0]    stk_addr,
  output logic [DW-1:0]      stk_wdata,
  output logic [SP_W-1:0]    sp_q
);
  localparam logic [CW-1:0] LAST = CW'(ENTRY_CYC - 1);

  seq_state_e      state;
  logic [CW-1:0]   cnt;
  logic [PC_W-1:0] ret_pc;
  logic [PC_W-1:0] vec_q;
  logic [DW-1:0]   hi_q;
  logic            reti_q;
  logic            ret_any;

  assign ret_any = ret_req | reti_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      cnt    <= '0;
      sp_q   <= SP_W'(SP_INIT);
      ret_pc <= '0;
      vec_q  <= '0;
      hi_q   <= '0;
      reti_q <= 1'b0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          cnt <= '0;
          if (ret_any) begin
            state  <= SEQ_LEAVE;
            reti_q <= reti_req;
          end else if (instr_done && any) begin
            state  <= SEQ_ENTER;
            ret_pc <= cur_pc;
            vec_q  <= vec_tbl[int'(win_idx)*PC_W +: PC_W];
          end
        end
        SEQ_ENTER: begin
          if (cnt < CW'(2)) sp_q <= sp_q - SP_W'(1);
          if (cnt == LAST) state <= SEQ_IDLE;
          cnt <= cnt + CW'(1);
        end
        SEQ_LEAVE: begin
          sp_q <= sp_q + SP_W'(1);
          if (cnt == CW'(0)) hi_q <= stk_rdata;
          else               state <= SEQ_IDLE;
          cnt <= cnt + CW'(1);
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    busy        = (state != SEQ_IDLE);
    g_clr       = (state == SEQ_IDLE) && !ret_any && instr_done && any;
    g_set       = (state == SEQ_LEAVE) && (cnt == CW'(1)) && reti_q;
    stk_we      = (state == SEQ_ENTER) && (cnt < CW'(2));
    stk_re      = (state == SEQ_LEAVE);
    stk_addr    = stk_re ? sp_q + SP_W'(1) : sp_q;
    stk_wdata   = (cnt == CW'(0)) ? ret_pc[DW-1:0]
                                  : {{PADW{1'b0}}, ret_pc[PC_W-1:DW]};
    pc_load     = ((state == SEQ_ENTER) && (cnt == LAST)) ||
                  ((state == SEQ_LEAVE) && (cnt == CW'(1)));
    pc_load_val = (state == SEQ_LEAVE) ? {hi_q[HI_W-1:0], stk_rdata} : vec_q;
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int         PC_W      = 12,
  parameter int         DW        = 8,
  parameter int         SP_W      = 8,
  parameter logic [7:0] SP_INIT   = 8'hFF,
  parameter int         NHW       = 4,
  parameter int         ENTRY_CYC = 5,
  parameter int         G_BIT     = 0,
  localparam int NREQ = NHW + 1,
  localparam int IW   = $clog2(NREQ)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_done,
  input  logic                 swi_req,
  input  logic [NHW-1:0]       irq_pend,
  input  logic [NHW-1:0]       irq_en,
  input  logic [PC_W-1:0]      cur_pc,
  input  logic [NREQ*PC_W-1:0] vec_tbl,
  input  logic                 ret_req,
  input  logic                 reti_req,
  input  logic                 sr_data_we,
  input  logic                 sr_ded_we,
  input  logic [DW-1:0]        sr_wdata,
  output logic [DW-1:0]        sr_q,
  output logic                 busy,
  output logic                 pc_load,
  output logic [PC_W-1:0]      pc_load_val,
  output logic                 stk_we,
  output logic                 stk_re,
  output logic [SP_W-1:0]      stk_addr,
  output logic [DW-1:0]        stk_wdata,
  input  logic [DW-1:0]        stk_rdata,
  output logic [SP_W-1:0]      sp_q
);
  logic [NREQ-1:0] req;
  logic [NREQ-1:0] grant;
  logic [IW-1:0]   win_idx;
  logic            any;
  logic            g_clr;
  logic            g_set;

  // Index 0 is the software request and ignores G; the rest are masked by G.
  assign req = {irq_pend & irq_en & {NHW{sr_q[G_BIT]}}, swi_req};

  irq_arbiter #(.NREQ(NREQ)) u_arb (
    .req     (req),
    .grant   (grant),
    .win_idx (win_idx),
    .any     (any)
  );

  irq_seq_fsm #(
    .PC_W(PC_W), .DW(DW), .SP_W(SP_W), .SP_INIT(SP_INIT),
    .NREQ(NREQ), .ENTRY_CYC(ENTRY_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_done  (instr_done),
    .any         (any),
    .win_idx     (win_idx),
    .vec_tbl     (vec_tbl),
    .cur_pc      (cur_pc),
    .ret_req     (ret_req),
    .reti_req    (reti_req),
    .stk_rdata   (stk_rdata),
    .busy        (busy),
    .g_clr       (g_clr),
    .g_set       (g_set),
    .pc_load     (pc_load),
    .pc_load_val (pc_load_val),
    .stk_we      (stk_we),
    .stk_re      (stk_re),
    .stk_addr    (stk_addr),
    .stk_wdata   (stk_wdata),
    .sp_q        (sp_q)
  );

  irq_status_reg #(.SR_W(DW), .G_BIT(G_BIT)) u_sr (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_we (sr_data_we),
    .ded_we  (sr_ded_we),
    .wdata   (sr_wdata),
    .g_clr   (g_clr),
    .g_set   (g_set),
    .sr_q    (sr_q)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int DW        = 8,
  parameter int SP_W      = 8,
  parameter int ENTRY_CYC = 5,
  parameter int G_BIT     = 0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_done,
  input logic            ret_req,
  input logic            reti_req,
  input logic            sr_ded_we,
  input logic [DW-1:0]   sr_q,
  input logic            busy,
  input logic            pc_load,
  input logic            stk_we,
  input logic            stk_re,
  input logic [SP_W-1:0] sp_q
);
  localparam logic [DW-1:0] NG_MASK = ~(DW'(1) << G_BIT);

  logic [15:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 16'd1;
    else           run <= '0;
  end

  p_start_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(ret_req || reti_req)) |-> $past(instr_done));

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == 16'(ENTRY_CYC) || run == 16'd2));

  p_load_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

  p_push_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |=> (sp_q == SP_W'($past(sp_q) - SP_W'(1))));

  p_one_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we && stk_re));

  p_g_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |-> !sr_q[G_BIT]);

  p_pop_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stk_re |=> (sp_q == SP_W'($past(sp_q) + SP_W'(1))));

  p_sr_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_ded_we |=> ((sr_q & NG_MASK) == ($past(sr_q) & NG_MASK)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pc_load) |=> busy);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .DW(DW), .SP_W(SP_W), .ENTRY_CYC(ENTRY_CYC), .G_BIT(G_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr_done (instr_done),
  .ret_req    (ret_req),
  .reti_req   (reti_req),
  .sr_ded_we  (sr_ded_we),
  .sr_q       (sr_q),
  .busy       (busy),
  .pc_load    (pc_load),
  .stk_we     (stk_we),
  .stk_re     (stk_re),
  .sp_q       (sp_q)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_done = 1'b0, swi_req = 1'b0;
  logic [3:0]  irq_pend = '0, irq_en = '0;
  logic [11:0] cur_pc = '0;
  logic [59:0] vec_tbl;
  logic        ret_req = 1'b0, reti_req = 1'b0;
  logic        sr_data_we = 1'b0, sr_ded_we = 1'b0;
  logic [7:0]  sr_wdata = '0;
  logic [7:0]  sr_q, stk_addr, stk_wdata, stk_rdata, sp_q;
  logic        busy, pc_load, stk_we, stk_re;
  logic [11:0] pc_load_val;
  logic [7:0]  smem [256];

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_sp = 8'hFF;

  always #2 clk = ~clk;

  always @(posedge clk) if (stk_we) smem[stk_addr] <= stk_wdata;
  assign stk_rdata = smem[stk_addr];

  irq_entry_seq u0 (.*);

  // fields: g, swi, pend[3:0], en[3:0], pc[11:0], expected index (7 = none)
  localparam logic [24:0] TBL [8] = '{
    {1'b1, 1'b0, 4'b1111, 4'b1111, 12'h123, 3'd1},
    {1'b1, 1'b0, 4'b0110, 4'b0111, 12'h234, 3'd2},
    {1'b1, 1'b1, 4'b1111, 4'b1111, 12'h345, 3'd0},
    {1'b0, 1'b1, 4'b0000, 4'b0000, 12'h456, 3'd0},
    {1'b0, 1'b0, 4'b1111, 4'b1111, 12'h567, 3'd7},
    {1'b1, 1'b0, 4'b1111, 4'b0000, 12'h678, 3'd7},
    {1'b1, 1'b0, 4'b1000, 4'b1000, 12'hFED, 3'd4},
    {1'b1, 1'b0, 4'b0101, 4'b0100, 12'h89A, 3'd3}
  };

  function automatic logic [11:0] vec_of(input int i);
    return 12'hA00 + 12'(i) * 12'h011;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, expv);
    end
  endtask

  task automatic sr_load(input logic [7:0] v, input bit ded);
    sr_wdata = v; sr_ded_we = ded; sr_data_we = !ded;
    @(negedge clk);
    sr_ded_we = 1'b0; sr_data_we = 1'b0;
  endtask

  task automatic enter(input int idx, input logic [11:0] pc);
    instr_done = 1'b1; cur_pc = pc;
    @(negedge clk);
    instr_done = 1'b0;
    for (int c = 0; c < 5; c++) begin
      chk("R3 busy in entry", busy, 1);
      if (c == 0) begin
        chk("R4 low push we", stk_we, 1);
        chk("R4 low push addr", stk_addr, exp_sp);
        chk("R4 low push data", stk_wdata, pc[7:0]);
        chk("R5 G cleared", sr_q[0], 0);
      end
      if (c == 1) begin
        chk("R4 high push addr", stk_addr, 8'(exp_sp - 8'd1));
        chk("R4 high push data", stk_wdata, {4'h0, pc[11:8]});
      end
      if (c == 4) begin
        chk("R3 pc_load", pc_load, 1);
        chk("R6 vector", pc_load_val, vec_of(idx));
      end else begin
        chk("R3 no early load", pc_load, 0);
      end
      @(negedge clk);
    end
    chk("R3 busy ends", busy, 0);
    exp_sp = exp_sp - 8'd2;
    chk("R4 sp after push", sp_q, exp_sp);
  endtask

  task automatic leave(input bit reti, input logic [11:0] pc, input bit exp_g);
    reti_req = reti; ret_req = !reti;
    @(negedge clk);
    reti_req = 1'b0; ret_req = 1'b0;
    chk(reti ? "R7 pop1 re" : "R8 pop1 re", stk_re, 1);
    chk("R7 pop1 addr", stk_addr, 8'(exp_sp + 8'd1));
    @(negedge clk);
    chk("R7 return load", pc_load, 1);
    chk(reti ? "R7 return pc" : "R8 return pc", pc_load_val, pc);
    @(negedge clk);
    chk("R7 busy ends", busy, 0);
    chk(reti ? "R7 G set" : "R8 G kept", sr_q[0], exp_g);
    exp_sp = exp_sp + 8'd2;
    chk("R7 sp restored", sp_q, exp_sp);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) vec_tbl[i*12 +: 12] = vec_of(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 sr", sr_q, 8'h00);
    chk("R11 sp", sp_q, 8'hFF);

    // R9 status write masking
    sr_load(8'hA6, 1'b1);
    chk("R9 dedicated load", sr_q, 8'hA6);
    sr_load(8'hFF, 1'b0);
    chk("R9 data write G only", sr_q, 8'hA7);
    sr_load(8'h50, 1'b0);
    chk("R9 data write clears G only", sr_q, 8'hA6);

    // R1 no acceptance without instruction completion
    sr_load(8'h01, 1'b1);
    irq_pend = 4'b0001; irq_en = 4'b0001; swi_req = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R1 waits for instr_done", busy, 0);
    end
    swi_req = 1'b0; irq_pend = '0; irq_en = '0;

    // Table walk: R2, R6, R7, R8
    foreach (TBL[n]) begin
      logic [24:0] v;
      v = TBL[n];
      sr_load({7'b0, v[24]}, 1'b1);
      swi_req = v[23]; irq_pend = v[22:19]; irq_en = v[18:15];
      if (v[2:0] == 3'd7) begin
        instr_done = 1'b1; cur_pc = v[14:3];
        @(negedge clk);
        instr_done = 1'b0;
        chk("R2 nothing qualifies", busy, 0);
        swi_req = 1'b0; irq_pend = '0; irq_en = '0;
      end else begin
        enter(int'(v[2:0]), v[14:3]);
        swi_req = 1'b0; irq_pend = '0; irq_en = '0;
        leave(v[24], v[14:3], v[24]);
      end
    end

    // R10 pending request during and after entry; nested software entry
    sr_load(8'h01, 1'b1);
    irq_pend = 4'b0001; irq_en = 4'b0001;
    instr_done = 1'b1; cur_pc = 12'h3C1;
    @(negedge clk);
    for (int c = 0; c < 5; c++) begin
      instr_done = 1'b1; swi_req = 1'b1;
      @(negedge clk);
    end
    swi_req = 1'b0;
    chk("R10 stray inputs kept entry", sp_q, 8'hFD);
    exp_sp = 8'hFD;
    @(negedge clk);
    chk("R10 masked after entry", busy, 0);
    swi_req = 1'b1;
    enter(0, 12'h5D2);
    swi_req = 1'b0; irq_pend = '0; irq_en = '0;
    leave(1'b0, 12'h5D2, 1'b0);
    leave(1'b1, 12'h3C1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule